// File: doc/BRIEF.md
# Address-Encoded FIFO Transfer Window

This block sits behind a host-side burst engine and serves burst reads and writes aimed at a reserved range of addresses. Any start address inside that range stands for a FIFO access. The number of bytes the host actually means to move is not sent separately: it is the distance from the start address to the top of the range. The burst itself carries its own byte count (a whole number of blocks, or a byte run), and the block always moves exactly that many beats on the host side.

For a host read, bytes are taken from a transmit FIFO that slave-side logic fills. Beats that fall past the encoded length come back as zero. For a host write, bytes go into a receive FIFO that slave-side logic drains, and beats past the encoded length are dropped. Two counters can be read as 32-bit words: a running total of bytes staged into the transmit FIFO, and a count of receive buffers granted to the host. A host can chain a block-mode burst and a byte-mode burst, each with its own encoded length, so that it moves an arbitrary total.

Top module: `fifo_window_xfer`

## Requirements
- R1: A command is accepted only when `cmd_addr` lies in the range 0x090 to 0x1F7FF inclusive. A command outside that range leaves the block idle and stores no data.
- R2: On acceptance the encoded length is latched as 0x1F800 minus `cmd_addr`. The burst ends (`xfer_active` low) after exactly `cmd_count` host beats, whatever that length is.
- R3: On a read burst, each `h_rreq` beat that falls inside the encoded length returns the next transmit-FIFO byte, in push order, on `h_rdata` with `h_rvalid` high in the following cycle.
- R4: Read beats past the encoded length return 0x00 and take nothing from the transmit FIFO.
- R5: On a write burst, `h_wdata` beats inside the encoded length enter the receive FIFO in order. Beats past it are discarded. The receive FIFO returns its bytes on `rx_data` one cycle after `rx_pop`.
- R6: A read beat inside the encoded length that finds the transmit FIFO empty returns 0x00 and sets `err_udf`. The flag stays set until reset.
- R7: A write beat inside the encoded length that finds the receive FIFO full is dropped and sets `err_ovf`. The flag stays set until reset. The FIFO keeps its first DEPTH bytes.
- R8: A register read with `reg_off` = 0x60 returns, in bits 19..0, the number of bytes accepted by `tx_push` since reset, modulo 2^20. Host reads do not change it.
- R9: A register read with `reg_off` = 0x44 returns the number of `tok_inc` pulses since reset, modulo 4096, in bits 27..16, with all other bits zero. Any other offset reads as zero. `reg_rdata` updates one cycle after `reg_rd`.
- R10: Bursts can be chained. A 1024-beat write at 0x1F800-1031 followed by an 8-beat write at 0x1F7F9 leaves exactly 1031 bytes in the receive FIFO.
- R11: After reset the block is idle, both FIFOs are empty, `h_rvalid` and both error flags are low, and both counters read zero.
- R12: A command that arrives while a burst is running, or a command with `cmd_count` = 0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Burst command strobe |
| cmd_addr | input | 17 | Burst start address |
| cmd_count | input | 18 | Host beats in the burst |
| cmd_wr | input | 1 | 1 = host writes, 0 = host reads |
| h_wvalid | input | 1 | Host write beat |
| h_wdata | input | 8 | Host write byte |
| h_rreq | input | 1 | Host read beat request |
| h_rvalid | output | 1 | Read byte valid, one cycle after request |
| h_rdata | output | 8 | Read byte |
| tx_push | input | 1 | Slave logic stages a byte for the host |
| tx_data | input | 8 | Byte being staged |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Slave logic takes a received byte |
| rx_data | output | 8 | Received byte, one cycle after pop |
| rx_empty | output | 1 | Receive FIFO empty |
| tok_inc | input | 1 | Grant one more receive buffer |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 8 | Register offset |
| reg_rdata | output | 32 | Register read data |
| xfer_active | output | 1 | Burst in progress |
| err_udf | output | 1 | Sticky transmit underflow flag |
| err_ovf | output | 1 | Sticky receive overflow flag |

## Verification
The bench goes after the boundary between the encoded length and the burst length in both directions. A design that counted the wrong limit would either leak FIFO bytes into the padding or zero out real bytes, and a design that popped during padding would shift every later read. It checks the window edges 0x08F, 0x1F7FF and 0x1F800, where an off-by-one design would accept a forbidden address or compute a wrapped length. The chained 1031-byte transfer catches a design that carries length state from one burst into the next. An underflow and a full receive FIFO are both forced, since a design that stalled, duplicated or failed to keep the flag would show up there.

// File: rtl/fwx_pkg.sv
package fwx_pkg;
  localparam int ADDR_W   = 17;
  localparam int WIN_LO   = 'h090;
  localparam int WIN_END  = 'h1F800;
  localparam int REG_AW   = 8;
  localparam int OFF_TOK  = 'h44;
  localparam int OFF_PKT  = 'h60;
  localparam int TOK_LSB  = 16;

  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} fwx_dir_e;
endpackage

// File: rtl/fwx_sync_fifo.sv
module fwx_sync_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CAP);
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> ($stable(wptr) && full));

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/fwx_burst_ctrl.sv
module fwx_burst_ctrl
  import fwx_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int CNT_W  = 18,
  parameter int LO     = WIN_LO,
  parameter int TOP    = WIN_END
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_wr,
  input  logic             h_wvalid,
  input  logic             h_rreq,
  input  logic             tx_empty,
  input  logic             rx_full,
  output logic             active,
  output logic             rx_push,
  output logic             tx_pop,
  output logic             rd_beat,
  output logic             udf_evt,
  output logic             ovf_evt
);
  fwx_dir_e         dir;
  logic [AW-1:0]    req_left;
  logic [CNT_W-1:0] beat_left;
  logic             in_win, start, beat, in_len;

  assign in_win  = (cmd_addr >= AW'(LO)) && (cmd_addr < AW'(TOP));
  assign start   = cmd_valid && !active && in_win && (cmd_count != '0);
  assign beat    = active && ((dir == DIR_WR) ? h_wvalid : h_rreq);
  assign in_len  = (req_left != '0);

  assign rx_push = beat && (dir == DIR_WR) && in_len && !rx_full;
  assign ovf_evt = beat && (dir == DIR_WR) && in_len && rx_full;
  assign rd_beat = beat && (dir == DIR_RD);
  assign tx_pop  = rd_beat && in_len && !tx_empty;
  assign udf_evt = rd_beat && in_len && tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      dir       <= DIR_RD;
      req_left  <= '0;
      beat_left <= '0;
    end else if (start) begin
      active    <= 1'b1;
      dir       <= cmd_wr ? DIR_WR : DIR_RD;
      req_left  <= AW'(TOP) - cmd_addr;
      beat_left <= cmd_count;
    end else if (beat) begin
      if (in_len) req_left <= req_left - 1'b1;
      beat_left <= beat_left - 1'b1;
      if (beat_left == CNT_W'(1)) active <= 1'b0;
    end
  end

  // R2
  last_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (beat && beat_left == CNT_W'(1)) |=> !active);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !beat) |=> ($stable(req_left) && $stable(beat_left) && active));

  // R1
  out_win_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && cmd_valid && !in_win) |=> !active);
endmodule

// File: rtl/fwx_regs.sv
module fwx_regs
  import fwx_pkg::*;
#(
  parameter int PKT_W = 20,
  parameter int TOK_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_pushed,
  input  logic              tok_inc,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_off,
  output logic [31:0]       reg_rdata
);
  logic [PKT_W-1:0] pkt_len;
  logic [TOK_W-1:0] tok_cnt;
  logic [31:0]      rd_mux;

  always_comb begin
    rd_mux = '0;
    if (reg_off == REG_AW'(OFF_PKT))      rd_mux = 32'(pkt_len);
    else if (reg_off == REG_AW'(OFF_TOK)) rd_mux = 32'(tok_cnt) << TOK_LSB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_len   <= '0;
      tok_cnt   <= '0;
      reg_rdata <= '0;
    end else begin
      if (tx_pushed) pkt_len <= pkt_len + 1'b1;
      if (tok_inc)   tok_cnt <= tok_cnt + 1'b1;
      if (reg_rd)    reg_rdata <= rd_mux;
    end
  end

  // R8
  pkt_step_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pushed |=> (pkt_len == $past(pkt_len) + 1'b1));

  // R9
  tok_step_chk: assert property (@(posedge clk) disable iff (rst)
    !tok_inc |=> $stable(tok_cnt));
endmodule

// File: rtl/fifo_window_xfer.sv
module fifo_window_xfer
  import fwx_pkg::*;
#(
  parameter int CNT_W    = 18,
  parameter int TX_DEPTH = 2048,
  parameter int RX_DEPTH = 2048,
  parameter int PKT_W    = 20,
  parameter int TOK_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_wr,
  input  logic              h_wvalid,
  input  logic [7:0]        h_wdata,
  input  logic              h_rreq,
  output logic              h_rvalid,
  output logic [7:0]        h_rdata,
  input  logic              tx_push,
  input  logic [7:0]        tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [7:0]        rx_data,
  output logic              rx_empty,
  input  logic              tok_inc,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_off,
  output logic [31:0]       reg_rdata,
  output logic              xfer_active,
  output logic              err_udf,
  output logic              err_ovf
);
  logic       tx_empty, rx_full;
  logic       rx_push_i, tx_pop_i, rd_beat, udf_evt, ovf_evt;
  logic       pad_q;
  logic [7:0] tx_dout;

  fwx_burst_ctrl #(.AW(ADDR_W), .CNT_W(CNT_W), .LO(WIN_LO), .TOP(WIN_END)) u_ctrl (
    .clk, .rst, .cmd_valid, .cmd_addr, .cmd_count, .cmd_wr,
    .h_wvalid, .h_rreq, .tx_empty, .rx_full,
    .active(xfer_active), .rx_push(rx_push_i), .tx_pop(tx_pop_i),
    .rd_beat, .udf_evt, .ovf_evt
  );

  fwx_sync_fifo #(.DW(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk, .rst, .push(tx_push), .din(tx_data), .pop(tx_pop_i),
    .dout(tx_dout), .full(tx_full), .empty(tx_empty)
  );

  fwx_sync_fifo #(.DW(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rst, .push(rx_push_i), .din(h_wdata), .pop(rx_pop),
    .dout(rx_data), .full(rx_full), .empty(rx_empty)
  );

  fwx_regs #(.PKT_W(PKT_W), .TOK_W(TOK_W)) u_regs (
    .clk, .rst, .tx_pushed(tx_push && !tx_full), .tok_inc,
    .reg_rd, .reg_off, .reg_rdata
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rvalid <= 1'b0;
      pad_q    <= 1'b1;
      err_udf  <= 1'b0;
      err_ovf  <= 1'b0;
    end else begin
      h_rvalid <= rd_beat;
      pad_q    <= !tx_pop_i;
      if (udf_evt) err_udf <= 1'b1;
      if (ovf_evt) err_ovf <= 1'b1;
    end
  end

  assign h_rdata = pad_q ? 8'h00 : tx_dout;

  // R6
  udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_udf |=> err_udf);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_ovf |=> err_ovf);

  // R3
  rvalid_origin_chk: assert property (@(posedge clk) disable iff (rst)
    h_rvalid |-> $past(xfer_active));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (h_rvalid && pad_q) |-> (h_rdata == 8'h00));
endmodule

// File: tb/tb_fifo_window_xfer.sv
module tb_fifo_window_xfer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 0;
  logic [16:0] cmd_addr = '0;
  logic [17:0] cmd_count = '0;
  logic        cmd_wr = 0;
  logic        h_wvalid = 0;
  logic [7:0]  h_wdata = '0;
  logic        h_rreq = 0;
  logic        h_rvalid;
  logic [7:0]  h_rdata;
  logic        tx_push = 0;
  logic [7:0]  tx_data = '0;
  logic        tx_full;
  logic        rx_pop = 0;
  logic [7:0]  rx_data;
  logic        rx_empty;
  logic        tok_inc = 0;
  logic        reg_rd = 0;
  logic [7:0]  reg_off = '0;
  logic [31:0] reg_rdata;
  logic        xfer_active, err_udf, err_ovf;

  int checks = 0;
  int fails = 0;
  int pushed_total = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fifo_window_xfer dut (
    .clk, .rst, .cmd_valid, .cmd_addr, .cmd_count, .cmd_wr,
    .h_wvalid, .h_wdata, .h_rreq, .h_rvalid, .h_rdata,
    .tx_push, .tx_data, .tx_full, .rx_pop, .rx_data, .rx_empty,
    .tok_inc, .reg_rd, .reg_off, .reg_rdata,
    .xfer_active, .err_udf, .err_ovf
  );

  localparam int NV = 7;
  localparam int V_ADDR [NV] = '{'h1F7FC, 'h1F7FE, 'h1F7FD, 'h1F7F0, 'h1F7FF, 'h090, 'h1F7F8};
  localparam int V_CNT  [NV] = '{4, 5, 6, 8, 3, 5, 8};
  localparam int V_WR   [NV] = '{0, 0, 1, 1, 0, 1, 0};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(int addr, int cnt, bit wr);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = 17'(addr); cmd_count = 18'(cnt); cmd_wr = wr;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic push_tx(logic [7:0] b);
    @(negedge clk);
    tx_push = 1; tx_data = b;
    @(negedge clk);
    tx_push = 0;
    pushed_total++;
  endtask

  task automatic wbeat(logic [7:0] b);
    @(negedge clk);
    h_wvalid = 1; h_wdata = b;
    @(negedge clk);
    h_wvalid = 0;
  endtask

  task automatic rbeat(output logic [7:0] b, output logic v);
    @(negedge clk);
    h_rreq = 1;
    @(negedge clk);
    h_rreq = 0;
    b = h_rdata; v = h_rvalid;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
    b = rx_data;
  endtask

  task automatic rd_reg(logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_off = off;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic        v;
    logic [31:0] d;
    int          n;
    int          req;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R11 reset state
    check("R11 active", 32'(xfer_active), 0);
    check("R11 rvalid", 32'(h_rvalid), 0);
    check("R11 errs", {30'd0, err_udf, err_ovf}, 0);
    check("R11 rx_empty", 32'(rx_empty), 1);
    rd_reg(8'h60, d); check("R11 pkt", d, 0);
    rd_reg(8'h44, d); check("R11 tok", d, 0);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      req = 'h1F800 - V_ADDR[i];
      n = (req < V_CNT[i]) ? req : V_CNT[i];
      if (V_WR[i] == 0) begin
        for (int k = 0; k < n; k++) push_tx(8'(8'h40 + i * 8 + k));
        issue(V_ADDR[i], V_CNT[i], 0);
        check("R2 start", 32'(xfer_active), 1);
        for (int k = 0; k < V_CNT[i]; k++) begin
          rbeat(b, v);
          check("R3 rvalid", 32'(v), 1);
          if (k < n) check("R3 data", 32'(b), 32'(8'(8'h40 + i * 8 + k)));
          else       check("R4 pad", 32'(b), 0);
        end
      end else begin
        issue(V_ADDR[i], V_CNT[i], 1);
        for (int k = 0; k < V_CNT[i]; k++) wbeat(8'(8'h80 + i * 8 + k));
        for (int k = 0; k < n; k++) begin
          pop_rx(b);
          check("R5 data", 32'(b), 32'(8'(8'h80 + i * 8 + k)));
        end
        check("R5 discard", 32'(rx_empty), 1);
      end
      check("R2 end", 32'(xfer_active), 0);
    end
    check("R6 clean", 32'(err_udf), 0);

    // R1 window edges
    issue('h08F, 2, 1);
    check("R1 low", 32'(xfer_active), 0);
    wbeat(8'h11);
    check("R1 low nodata", 32'(rx_empty), 1);
    issue('h1F800, 2, 1);
    check("R1 high", 32'(xfer_active), 0);
    wbeat(8'h12);
    check("R1 high nodata", 32'(rx_empty), 1);

    // R12 zero count, busy command
    issue('h1F700, 0, 1);
    check("R12 zero count", 32'(xfer_active), 0);
    issue('h1F7FE, 3, 1);
    issue('h1F700, 1, 0);
    wbeat(8'hA1); wbeat(8'hA2);
    check("R12 busy still", 32'(xfer_active), 1);
    wbeat(8'hA3);
    check("R12 busy end", 32'(xfer_active), 0);
    pop_rx(b); check("R12 d0", 32'(b), 32'hA1);
    pop_rx(b); check("R12 d1", 32'(b), 32'hA2);
    check("R12 empty", 32'(rx_empty), 1);

    // R6 underflow
    push_tx(8'h5A);
    issue('h1F7FD, 3, 0);
    rbeat(b, v); check("R6 first", 32'(b), 32'h5A);
    check("R6 not yet", 32'(err_udf), 0);
    rbeat(b, v); check("R6 zero", 32'(b), 0);
    rbeat(b, v); check("R6 zero2", 32'(b), 0);
    check("R6 flag", 32'(err_udf), 1);
    issue('h1F7FF, 1, 1); wbeat(8'h01); pop_rx(b);
    check("R6 sticky", 32'(err_udf), 1);

    // R8 R9 registers
    rd_reg(8'h60, d); check("R8 pkt", d, 32'(pushed_total));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); tok_inc = 1;
      @(negedge clk); tok_inc = 0;
    end
    rd_reg(8'h44, d); check("R9 tok", d, 32'(5) << 16);
    rd_reg(8'h50, d); check("R9 other", d, 0);

    // R10 chained bursts
    issue('h1F800 - 1031, 1024, 1);
    for (int k = 0; k < 1024; k++) wbeat(8'(k));
    issue('h1F7F9, 8, 1);
    for (int k = 0; k < 8; k++) wbeat(8'(1024 + k));
    n = 0;
    for (int k = 0; k < 1031; k++) begin
      pop_rx(b);
      if (b !== 8'(k)) n++;
    end
    check("R10 order", 32'(n), 0);
    check("R10 count", 32'(rx_empty), 1);
    check("R10 no ovf", 32'(err_ovf), 0);

    // R7 overflow
    issue('h090, 2050, 1);
    for (int k = 0; k < 2050; k++) wbeat(8'(k + 3));
    check("R7 flag", 32'(err_ovf), 1);
    n = 0;
    for (int k = 0; k < 2048; k++) begin
      pop_rx(b);
      if (b !== 8'(k + 3)) n++;
    end
    check("R7 kept", 32'(n), 0);
    check("R7 dropped", 32'(rx_empty), 1);
    check("R7 sticky", 32'(err_ovf), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule